// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block sits between the store pipeline and the data cache of an out-of-order core. A store that has produced its address and data is placed in the buffer straight away, but it stays marked speculative and cannot reach memory. When the store's instruction retires, the commit port names it by its tag. That clears the speculative mark, and the entry then waits its turn to drain through the cache write port. If the instruction is squashed, the kill port removes the entry, and the store never produces a cache write.

Loads probe the buffer in the same cycle as their cache access. The probe looks only at stores that are older in program order than the load. Among those older stores whose word address matches, the youngest one supplies the data. A hit from the buffer overrides whatever the cache returns. Committed stores that are still waiting to drain also answer probes.

Top module: `store_spec_buf`

## Requirements
- R1: After synchronous reset the buffer is empty: `alloc_ready` is 1, `cache_wr_valid` is 0 and a probe never hits.
- R2: A store that has not been committed never drives `cache_wr_valid`.
- R3: A commit whose tag matches a speculative entry makes that entry eligible to drain. Once it reaches the oldest position, `cache_wr_valid` is 1 with its address and data.
- R4: Committed stores drain strictly in allocation order, at most one per cycle, and only in a cycle where `cache_wr_ready` is 1. While `cache_wr_ready` is 0, the offered address and data hold steady.
- R5: A kill with age K frees every speculative entry whose age is not older than K, with no cache write. An allocation offered in the same cycle as a kill is refused (`alloc_ready` is 0).
- R6: A probe considers only stores strictly older than the load. A store of equal or younger age never hits.
- R7: When several older stores match the probe address, `ld_data` comes from the most recently allocated of them.
- R8: With no older matching store, `ld_hit` is 0 and `ld_data` is 0. Committed stores that have not yet drained still forward.
- R9: With all DEPTH entries occupied, `alloc_ready` is 0 and an offered store is dropped.
- R10: Ages wrap around. Store age A counts as older than age B when (B − A) mod 2^AGE_W is non-zero and below 2^(AGE_W−1).
- R11: A commit and a kill in the same cycle that both cover one entry leave that entry committed, not freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Store offered for insertion |
| alloc_ready | output | 1 | Buffer accepts the offered store this cycle |
| alloc_addr | input | ADDR_W | Word address of the store |
| alloc_data | input | DATA_W | Store data |
| alloc_tag | input | TAG_W | Instruction tag of the store |
| alloc_age | input | AGE_W | Program-order age of the store |
| commit_valid | input | 1 | Commit request |
| commit_tag | input | TAG_W | Tag of the retiring store |
| kill_valid | input | 1 | Squash request |
| kill_age | input | AGE_W | Oldest age being squashed |
| ld_valid | input | 1 | Load probe present |
| ld_addr | input | ADDR_W | Word address of the load |
| ld_age | input | AGE_W | Program-order age of the load |
| ld_hit | output | 1 | An older store supplies the load |
| ld_data | output | DATA_W | Forwarded data |
| cache_wr_valid | output | 1 | Oldest entry is committed and offered to the cache |
| cache_wr_ready | input | 1 | Cache takes the offered write |
| cache_wr_addr | output | ADDR_W | Address of the offered write |
| cache_wr_data | output | DATA_W | Data of the offered write |

## Verification
The bench targets these corner cases and the failure each one would expose:
- Probes at exactly the store's age and one age unit on either side. A design that treated "not younger" as "older" would forward a store to its own load.
- Two stores to one address. A wrong priority order would return the older store's data.
- A kill that splits the buffer. It checks that the committed head survives and keeps forwarding while the killed entries go silent.
- A full buffer that drains under back-pressure. Any drop, reorder or double pop would show up in the drained address sequence.
- Ages across the wrap point. A plain magnitude compare would reverse the answer.
- A commit and a kill in the same cycle. A design that ordered them the wrong way would lose a retired store.

// File: rtl/ssb_pkg.sv
// Package: shared helpers for the speculative store buffer.
// Assumes ages are sequence numbers no wider than 31 bits that wrap.
package ssb_pkg;

    // True when age a precedes age b in program order (wrap-aware).
    function automatic logic ssb_is_older(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input int unsigned w);
        logic [31:0] mask;
        logic [31:0] diff;
        mask = (32'd1 << w) - 32'd1;
        diff = (b - a) & mask;
        return (diff != 32'd0) && (diff[w-1] == 1'b0);
    endfunction

endpackage

// File: rtl/ssb_entry.sv
// Module: one slot of the store buffer.
// Holds address, data, tag and age, plus a valid bit and a speculative bit.
// Assumes the slot is written only while it is empty, and that commit tags
// are unique among speculative slots.
// A commit in the same cycle as a kill protects the slot.
module ssb_entry #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6,
    parameter int AGE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [AGE_W-1:0]  wr_age,
    input  logic              commit_valid,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic              kill_valid,
    input  logic [AGE_W-1:0]  kill_age,
    input  logic              pop_en,
    output logic              busy,
    output logic              spec,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic [AGE_W-1:0]  age,
    output logic              kill_hit
);
    import ssb_pkg::*;

    logic [TAG_W-1:0] tag_q;
    logic             commit_hit;

    // Decide whether this slot is retired or squashed this cycle.
    always_comb begin
        commit_hit = commit_valid && busy && spec && (tag_q == commit_tag);
        kill_hit   = kill_valid && busy && spec && !commit_hit &&
                     !ssb_is_older(32'(age), 32'(kill_age), AGE_W);
    end

    // Update the slot state: pop, squash, fill, or retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            spec <= 1'b0;
        end else if (pop_en || kill_hit) begin
            busy <= 1'b0;
            spec <= 1'b0;
        end else if (wr_en) begin
            busy <= 1'b1;
            spec <= 1'b1;
        end else if (commit_hit) begin
            spec <= 1'b0;
        end
    end

    // Capture the payload on fill; no reset is needed for data fields.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr  <= wr_addr;
            data  <= wr_data;
            tag_q <= wr_tag;
            age   <= wr_age;
        end
    end

endmodule

// File: rtl/ssb_ptr_ctrl.sv
// Module: ring pointers and occupancy for the store buffer.
// Assumes DEPTH is a power of two and that killed slots always form the
// youngest run of the ring, because allocation follows program order.
module ssb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] kill_cnt,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count
);
    logic [PTR_W-1:0] kill_ptr;

    // Reduce the kill count to a ring distance (DEPTH wraps to zero).
    always_comb kill_ptr = PTR_W'(kill_cnt);

    // Advance the head on a pop, and move the tail by pushes minus squashes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head + PTR_W'(pop);
            tail  <= tail + PTR_W'(push) - kill_ptr;
            count <= count + CNT_W'(push) - CNT_W'(pop) - kill_cnt;
        end
    end

endmodule

// File: rtl/ssb_fwd_select.sv
// Module: load forwarding search.
// Walks the ring from oldest to youngest, so the last qualifying match wins.
// Assumes the ring order starting at head is allocation order.
module ssb_fwd_select #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int AGE_W  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             busy,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] data,
    input  logic [DEPTH-1:0][AGE_W-1:0]  age,
    input  logic [PTR_W-1:0]             head,
    input  logic                         ld_valid,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [AGE_W-1:0]             ld_age,
    output logic                         hit,
    output logic [DATA_W-1:0]            hit_data
);
    import ssb_pkg::*;

    // Pick the youngest older store whose address matches the load.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int unsigned i = 0; i < DEPTH; i++) begin
            logic [PTR_W-1:0] idx;
            idx = head + PTR_W'(i);
            if (ld_valid && busy[idx] && (addr[idx] == ld_addr) &&
                ssb_is_older(32'(age[idx]), 32'(ld_age), AGE_W)) begin
                hit      = 1'b1;
                hit_data = data[idx];
            end
        end
    end

endmodule

// File: rtl/store_spec_buf.sv
// Module: speculative store buffer with load forwarding (top).
// Stores enter speculative, retire by tag, are squashed by age, and drain in
// order to the cache. Loads get data from the youngest older matching store.
// Assumes stores arrive in program order, commits follow program order and
// tags are unique among live speculative entries.
module store_spec_buf #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6,
    parameter int AGE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [AGE_W-1:0]  alloc_age,
    input  logic              commit_valid,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic              kill_valid,
    input  logic [AGE_W-1:0]  kill_age,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [AGE_W-1:0]  ld_age,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              cache_wr_valid,
    input  logic              cache_wr_ready,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]             busy_vec;
    logic [DEPTH-1:0]             spec_vec;
    logic [DEPTH-1:0]             kill_vec;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_arr;
    logic [DEPTH-1:0][DATA_W-1:0] data_arr;
    logic [DEPTH-1:0][AGE_W-1:0]  age_arr;
    logic [PTR_W-1:0]             head;
    logic [PTR_W-1:0]             tail;
    logic [CNT_W-1:0]             count;
    logic [CNT_W-1:0]             kill_cnt;
    logic                         push;
    logic                         pop;

    // Accept a store only with room and no squash in flight.
    always_comb begin
        alloc_ready = (count < CNT_W'(DEPTH)) && !kill_valid;
        push        = alloc_valid && alloc_ready;
    end

    // Offer the oldest entry to the cache once it has retired.
    always_comb begin
        cache_wr_valid = busy_vec[head] && !spec_vec[head];
        cache_wr_addr  = addr_arr[head];
        cache_wr_data  = data_arr[head];
        pop            = cache_wr_valid && cache_wr_ready;
    end

    // Count the slots squashed this cycle.
    always_comb begin
        kill_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            kill_cnt = kill_cnt + CNT_W'(kill_vec[i]);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        ssb_entry #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W),
            .TAG_W (TAG_W),
            .AGE_W (AGE_W)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (push && (tail == PTR_W'(g))),
            .wr_addr     (alloc_addr),
            .wr_data     (alloc_data),
            .wr_tag      (alloc_tag),
            .wr_age      (alloc_age),
            .commit_valid(commit_valid),
            .commit_tag  (commit_tag),
            .kill_valid  (kill_valid),
            .kill_age    (kill_age),
            .pop_en      (pop && (head == PTR_W'(g))),
            .busy        (busy_vec[g]),
            .spec        (spec_vec[g]),
            .addr        (addr_arr[g]),
            .data        (data_arr[g]),
            .age         (age_arr[g]),
            .kill_hit    (kill_vec[g])
        );
    end

    ssb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .kill_cnt(kill_cnt),
        .head    (head),
        .tail    (tail),
        .count   (count)
    );

    ssb_fwd_select #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .AGE_W (AGE_W)
    ) u_fwd (
        .busy    (busy_vec),
        .addr    (addr_arr),
        .data    (data_arr),
        .age     (age_arr),
        .head    (head),
        .ld_valid(ld_valid),
        .ld_addr (ld_addr),
        .ld_age  (ld_age),
        .hit     (ld_hit),
        .hit_data(ld_data)
    );

endmodule

// File: rtl/ssb_checker.sv
// Module: protocol and consistency properties for store_spec_buf, bound in.
// Assumes it observes the occupancy counter and the per-slot valid bits.
module ssb_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              alloc_ready,
    input logic              kill_valid,
    input logic              ld_valid,
    input logic              ld_hit,
    input logic              cache_wr_valid,
    input logic              cache_wr_ready,
    input logic [ADDR_W-1:0] cache_wr_addr,
    input logic [DATA_W-1:0] cache_wr_data,
    input logic [DEPTH-1:0]  busy_vec,
    input logic [CNT_W-1:0]  count
);
    // Counter and slot bits agree (R9 occupancy tracking).
    p_count_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_vec) == 32'(count));

    // No store is accepted into a full ring (R9).
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |-> ($countones(busy_vec) < DEPTH));

    // A stalled drain holds its offer (R4).
    p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_valid && !cache_wr_ready) |=>
        (cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_data)));

    // A squash never grows the buffer (R5).
    p_kill_no_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |=> (count <= $past(count)));

    // Forwarding needs a probe and a live entry (R8).
    p_hit_needs_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> (ld_valid && (busy_vec != '0)));

    // The reset state is empty (R1).
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (busy_vec == '0));
endmodule

bind store_spec_buf ssb_checker #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .kill_valid    (kill_valid),
    .ld_valid      (ld_valid),
    .ld_hit        (ld_hit),
    .cache_wr_valid(cache_wr_valid),
    .cache_wr_ready(cache_wr_ready),
    .cache_wr_addr (cache_wr_addr),
    .cache_wr_data (cache_wr_data),
    .busy_vec      (busy_vec),
    .count         (count)
);

// File: tb/test_store_spec_buf.sv
module test_store_spec_buf;
    localparam int DEPTH = 8;

    localparam logic [2:0] OP_ALLOC  = 3'd0;
    localparam logic [2:0] OP_COMMIT = 3'd1;
    localparam logic [2:0] OP_KILL   = 3'd2;
    localparam logic [2:0] OP_LOAD   = 3'd3;
    localparam logic [2:0] OP_CWCHK  = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [5:0]  tag;
        logic [7:0]  age;
        logic        exp_hit;
        logic [31:0] exp_data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    // Fields: op, addr, data, tag, age, expected hit/valid, expected data, requirement.
    localparam vec_t VECS [NV] = '{
        '{OP_ALLOC,  32'h10, 32'hA1, 6'd1, 8'd10, 1'b0, 32'h0,  4'd0},
        '{OP_ALLOC,  32'h10, 32'hA2, 6'd2, 8'd12, 1'b0, 32'h0,  4'd0},
        '{OP_ALLOC,  32'h20, 32'hB1, 6'd3, 8'd14, 1'b0, 32'h0,  4'd0},
        '{OP_CWCHK,  32'h0,  32'h0,  6'd0, 8'd0,  1'b0, 32'h0,  4'd2},   // R2 nothing drains
        '{OP_LOAD,   32'h10, 32'h0,  6'd0, 8'd11, 1'b1, 32'hA1, 4'd6},   // R6 only the older one
        '{OP_LOAD,   32'h10, 32'h0,  6'd0, 8'd13, 1'b1, 32'hA2, 4'd7},   // R7 youngest older
        '{OP_LOAD,   32'h10, 32'h0,  6'd0, 8'd10, 1'b0, 32'h0,  4'd6},   // R6 equal age
        '{OP_LOAD,   32'h10, 32'h0,  6'd0, 8'd9,  1'b0, 32'h0,  4'd6},   // R6 younger store
        '{OP_LOAD,   32'h30, 32'h0,  6'd0, 8'd20, 1'b0, 32'h0,  4'd8},   // R8 no match
        '{OP_LOAD,   32'h20, 32'h0,  6'd0, 8'd20, 1'b1, 32'hB1, 4'd7},
        '{OP_COMMIT, 32'h0,  32'h0,  6'd1, 8'd0,  1'b0, 32'h0,  4'd0},
        '{OP_CWCHK,  32'h0,  32'h0,  6'd0, 8'd0,  1'b1, 32'hA1, 4'd3},   // R3 retired head offered
        '{OP_LOAD,   32'h10, 32'h0,  6'd0, 8'd30, 1'b1, 32'hA2, 4'd7},
        '{OP_KILL,   32'h0,  32'h0,  6'd0, 8'd12, 1'b0, 32'h0,  4'd0},
        '{OP_LOAD,   32'h10, 32'h0,  6'd0, 8'd30, 1'b1, 32'hA1, 4'd5},   // R5 killed store silent
        '{OP_LOAD,   32'h20, 32'h0,  6'd0, 8'd30, 1'b0, 32'h0,  4'd5},
        '{OP_CWCHK,  32'h0,  32'h0,  6'd0, 8'd0,  1'b1, 32'hA1, 4'd8}    // R8 committed survives
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic        alloc_ready;
    logic [31:0] alloc_addr = '0;
    logic [31:0] alloc_data = '0;
    logic [5:0]  alloc_tag = '0;
    logic [7:0]  alloc_age = '0;
    logic        commit_valid = 1'b0;
    logic [5:0]  commit_tag = '0;
    logic        kill_valid = 1'b0;
    logic [7:0]  kill_age = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [7:0]  ld_age = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        cache_wr_valid;
    logic        cache_wr_ready = 1'b0;
    logic [31:0] cache_wr_addr;
    logic [31:0] cache_wr_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    store_spec_buf i_store_spec_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_addr(alloc_addr), .alloc_data(alloc_data),
        .alloc_tag(alloc_tag), .alloc_age(alloc_age),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .kill_valid(kill_valid), .kill_age(kill_age),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
        .ld_hit(ld_hit), .ld_data(ld_data),
        .cache_wr_valid(cache_wr_valid), .cache_wr_ready(cache_wr_ready),
        .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_alloc(input logic [31:0] a, input logic [31:0] d,
                            input logic [5:0] t, input logic [7:0] g);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_addr = a; alloc_data = d; alloc_tag = t; alloc_age = g;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic do_commit(input logic [5:0] t);
        @(negedge clk);
        commit_valid = 1'b1; commit_tag = t;
        @(posedge clk); #1;
        commit_valid = 1'b0;
    endtask

    task automatic do_kill(input logic [7:0] g);
        @(negedge clk);
        kill_valid = 1'b1; kill_age = g;
        @(posedge clk); #1;
        kill_valid = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] a, input logic [7:0] g, input bit eh,
                           input logic [31:0] ed, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_age = g;
        #1;
        check(ld_hit == eh, req, 32'(ld_hit), 32'(eh));
        if (eh) check(ld_data == ed, req, ld_data, ed);
        else    check(ld_data == 32'h0, req, ld_data, 32'h0);
        ld_valid = 1'b0;
    endtask

    task automatic do_cwchk(input bit ev, input logic [31:0] ed, input string req);
        @(negedge clk);
        check(cache_wr_valid == ev, req, 32'(cache_wr_valid), 32'(ev));
        if (ev) check(cache_wr_data == ed, req, cache_wr_data, ed);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 32'h0; ld_age = 8'd5;
        #1;
        check(alloc_ready == 1'b1, "R1", 32'(alloc_ready), 32'd1);
        check(cache_wr_valid == 1'b0, "R1", 32'(cache_wr_valid), 32'd0);
        check(ld_hit == 1'b0, "R1", 32'(ld_hit), 32'd0);
        ld_valid = 1'b0;

        // Vector walk, no draining
        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[v].req);
            case (VECS[v].op)
                OP_ALLOC:  do_alloc(VECS[v].addr, VECS[v].data, VECS[v].tag, VECS[v].age);
                OP_COMMIT: do_commit(VECS[v].tag);
                OP_KILL:   do_kill(VECS[v].age);
                OP_LOAD:   do_load(VECS[v].addr, VECS[v].age, VECS[v].exp_hit,
                                   VECS[v].exp_data, rq);
                default:   do_cwchk(VECS[v].exp_hit, VECS[v].exp_data, rq);
            endcase
        end

        // R4 drain the single committed entry; exactly one pop
        @(negedge clk);
        cache_wr_ready = 1'b1;
        @(posedge clk); #1;
        cache_wr_ready = 1'b0;
        do_cwchk(1'b0, 32'h0, "R4");

        // R9 fill all slots, then offer one more
        for (int k = 0; k < DEPTH; k++)
            do_alloc(32'h100 + 32'(k), 32'hC0 + 32'(k), 6'd10 + 6'(k), 8'd50 + 8'(k));
        @(negedge clk);
        check(alloc_ready == 1'b0, "R9", 32'(alloc_ready), 32'd0);
        do_alloc(32'h999, 32'hDEAD, 6'd40, 8'd70);
        for (int k = 0; k < DEPTH; k++) do_commit(6'd10 + 6'(k));

        // R4 hold under back-pressure
        do_cwchk(1'b1, 32'hC0, "R4");
        check(cache_wr_addr == 32'h100, "R4", cache_wr_addr, 32'h100);
        do_cwchk(1'b1, 32'hC0, "R4");

        // R4 one pop per cycle in allocation order
        @(negedge clk);
        cache_wr_ready = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            check(cache_wr_valid && (cache_wr_addr == 32'h100 + 32'(k)), "R4",
                  cache_wr_addr, 32'h100 + 32'(k));
            @(negedge clk);
        end
        cache_wr_ready = 1'b0;
        check(cache_wr_valid == 1'b0, "R9", 32'(cache_wr_valid), 32'd0);
        check(alloc_ready == 1'b1, "R9", 32'(alloc_ready), 32'd1);

        // R10 wrap-around ages
        do_alloc(32'h40, 32'hE1, 6'd20, 8'd250);
        do_load(32'h40, 8'd3, 1'b1, 32'hE1, "R10");
        do_load(32'h40, 8'd130, 1'b0, 32'h0, "R10");
        do_kill(8'd250);
        do_load(32'h40, 8'd3, 1'b0, 32'h0, "R5");

        // R5 allocation offered during a kill is refused
        @(negedge clk);
        alloc_valid = 1'b1; alloc_addr = 32'h50; alloc_data = 32'hF5;
        alloc_tag = 6'd21; alloc_age = 8'd60;
        kill_valid = 1'b1; kill_age = 8'd200;
        #1;
        check(alloc_ready == 1'b0, "R5", 32'(alloc_ready), 32'd0);
        @(posedge clk); #1;
        alloc_valid = 1'b0; kill_valid = 1'b0;
        do_load(32'h50, 8'd100, 1'b0, 32'h0, "R5");
        do_cwchk(1'b0, 32'h0, "R5");

        // R11 commit beats a simultaneous kill
        do_alloc(32'h60, 32'hD7, 6'd7, 8'd70);
        @(negedge clk);
        commit_valid = 1'b1; commit_tag = 6'd7;
        kill_valid = 1'b1; kill_age = 8'd60;
        @(posedge clk); #1;
        commit_valid = 1'b0; kill_valid = 1'b0;
        do_cwchk(1'b1, 32'hD7, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule